// File: doc/BRIEF.md
# Nibble RAM Bit-Operation Unit

This unit is the data-memory side of a small 4-bit processor core. It holds a pointer made of a 4-bit low part (column) and a narrower high part (bank). From the pointer it forms the address of a nibble-wide data RAM. The sequencer hands it each instruction's opcode and operand byte. The unit then runs that instruction's data-memory work: it loads the pointer from an immediate operand, or it sets, clears or tests one bit of the addressed nibble.

Each instruction takes two clock cycles. In the first cycle the unit presents the address to a RAM with synchronous read. In the second cycle the read nibble comes back, and the unit either writes the modified nibble or raises a skip request for the sequencer. A one-byte prefix opcode forces the top address bit to 1 for the single instruction that follows it. The unit keeps its own record of whether the instruction just finished was that prefix. The sequencer can mark an instruction as skipped; the unit then treats it as a no-op.

Top module: `nram_bitop_unit`

## Requirements
- R1: After reset `ram_addr` is 0, and `ram_we` and `skip_req` are 0.
- R2: Without a prefix, `ram_addr` is the bank register in the upper bits over the column register in the low 4 bits, truncated to `DATA_AW` bits, and it is the same in both cycles of an instruction.
- R3: Opcode 0x5F loads the column register with operand bits 3:0 and the bank register with operand bits `DATA_AW-1`:4, dropping higher bits. The new value appears on `ram_addr` from the next instruction.
- R4: When the instruction that completed just before was opcode 0x02, bit `DATA_AW-1` of `ram_addr` is 1 for the current instruction's read and write. The instruction after that uses the bank register again.
- R5: Bit operations act on the bit numbered by opcode bits 1:0 (0 = LSB of the nibble).
- R6: Opcodes 0x04 to 0x07 write back the read nibble with the selected bit cleared and the other three bits unchanged.
- R7: Opcodes 0x0C to 0x0F write back the read nibble with the selected bit set and the other three bits unchanged.
- R8: Opcodes 0x54 to 0x57 raise `skip_req` in the second cycle exactly when the selected bit of the read nibble is 1, and perform no write.
- R9: An instruction issued with `ins_kill` high acts as opcode 0x00. It writes nothing, requests no skip, leaves the pointer unchanged, and does not act as a prefix.
- R10: `ram_we` and `skip_req` are high only in the second cycle of a bit-operation instruction. No other opcode writes or skips.
- R11: `ins_valid` during the second cycle of an instruction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction start strobe (first cycle) |
| ins_op | input | 8 | Opcode of the instruction |
| ins_operand | input | 8 | Second byte of the instruction |
| ins_kill | input | 1 | Instruction is skipped; treat it as a no-op |
| ram_addr | output | DATA_AW | Data RAM nibble address |
| ram_rdata | input | 4 | RAM read data, valid one cycle after the address |
| ram_wdata | output | 4 | RAM write data |
| ram_we | output | 1 | RAM write enable, second cycle only |
| skip_req | output | 1 | Request to skip the next instruction |

## Verification
The bench walks through all four bit positions with set, clear and test. A wrong bit decoder would write or test a neighbouring bit, and the mismatch would show up on the next test. The prefix is checked on the instruction right after it and again on the one after that. A flag held too long would keep sending writes to the upper half of RAM; a flag that never took effect would send them to the lower half. Skipped instructions and a stray strobe in the second cycle are checked to leave both the RAM contents and the pointer untouched. A load operand with bit 7 set checks that the bank register drops the bits it cannot hold.

// File: rtl/nram_pkg.sv
package nram_pkg;
   localparam logic [7:0] OP_NOP    = 8'h00;
   localparam logic [7:0] OP_PREFIX = 8'h02;
   localparam logic [7:0] OP_LDPTR  = 8'h5F;
   localparam logic [7:0] OP_CLRB   = 8'h04;
   localparam logic [7:0] OP_SETB   = 8'h0C;
   localparam logic [7:0] OP_TSTB   = 8'h54;
   localparam logic [7:0] BITOP_SEL = 8'hFC;

   typedef enum logic [1:0] {K_NONE, K_CLR, K_SET, K_TST} bitop_e;

   function automatic bitop_e decode_bitop(input logic [7:0] op);
      if ((op & BITOP_SEL) == OP_CLRB)      return K_CLR;
      else if ((op & BITOP_SEL) == OP_SETB) return K_SET;
      else if ((op & BITOP_SEL) == OP_TSTB) return K_TST;
      else                                  return K_NONE;
   endfunction
endpackage

// File: rtl/nram_seq.sv
module nram_seq
   import nram_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ins_valid,
   input  logic [7:0] ins_op,
   input  logic [7:0] ins_operand,
   input  logic       ins_kill,
   output logic       phase_b,
   output logic [7:0] exec_op,
   output logic [7:0] opd_q
);
   logic accept;
   assign accept = ins_valid && !phase_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_b <= 1'b0;
         exec_op <= OP_NOP;
         opd_q   <= '0;
      end else begin
         phase_b <= accept;
         if (accept) begin
            exec_op <= ins_kill ? OP_NOP : ins_op;
            opd_q   <= ins_operand;
         end
      end
   end
endmodule

// File: rtl/nram_addr_gen.sv
module nram_addr_gen
   import nram_pkg::*;
#(
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          phase_b,
   input  logic [7:0]    exec_op,
   input  logic [7:0]    opd_q,
   output logic [AW-1:0] ram_addr,
   output logic          prefix_q
);
   localparam int BMW = AW - 4;
   localparam logic [AW-1:0] HI_BIT = {1'b1, {(AW-1){1'b0}}};

   logic [3:0]     col_q;
   logic [BMW-1:0] bank_q;
   logic [AW-1:0]  raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q    <= '0;
         bank_q   <= '0;
         prefix_q <= 1'b0;
      end else if (phase_b) begin
         prefix_q <= (exec_op == OP_PREFIX);
         if (exec_op == OP_LDPTR) begin
            col_q  <= opd_q[3:0];
            bank_q <= opd_q[AW-1:4];
         end
      end
   end

   assign raw      = {bank_q, col_q};
   assign ram_addr = prefix_q ? (raw | HI_BIT) : raw;
endmodule

// File: rtl/nram_bit_alu.sv
module nram_bit_alu
   import nram_pkg::*;
(
   input  logic       phase_b,
   input  logic [7:0] exec_op,
   input  logic [3:0] ram_rdata,
   output logic [3:0] ram_wdata,
   output logic       ram_we,
   output logic       skip_req
);
   bitop_e     kind;
   logic [1:0] bsel;
   logic       fill;

   assign kind = decode_bitop(exec_op);
   assign bsel = exec_op[1:0];
   assign fill = (kind == K_SET);

   for (genvar i = 0; i < 4; i++) begin : g_bit
      assign ram_wdata[i] = (bsel == 2'(i)) ? fill : ram_rdata[i];
   end

   assign ram_we   = phase_b && (kind == K_CLR || kind == K_SET);
   assign skip_req = phase_b && (kind == K_TST) && ram_rdata[bsel];
endmodule

// File: rtl/nram_bitop_unit.sv
module nram_bitop_unit
   import nram_pkg::*;
#(
   parameter int DATA_AW = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ins_valid,
   input  logic [7:0]         ins_op,
   input  logic [7:0]         ins_operand,
   input  logic               ins_kill,
   output logic [DATA_AW-1:0] ram_addr,
   input  logic [3:0]         ram_rdata,
   output logic [3:0]         ram_wdata,
   output logic               ram_we,
   output logic               skip_req
);
   if (DATA_AW < 5 || DATA_AW > 8) begin : g_bad_aw
      $error("nram_bitop_unit: DATA_AW must lie in 5..8");
   end

   logic       phase_b;
   logic [7:0] exec_op;
   logic [7:0] opd_q;
   logic       prefix_q;

   nram_seq u_seq (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
      .ins_operand(ins_operand), .ins_kill(ins_kill),
      .phase_b(phase_b), .exec_op(exec_op), .opd_q(opd_q)
   );

   nram_addr_gen #(.AW(DATA_AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .phase_b(phase_b), .exec_op(exec_op),
      .opd_q(opd_q), .ram_addr(ram_addr), .prefix_q(prefix_q)
   );

   nram_bit_alu u_alu (
      .phase_b(phase_b), .exec_op(exec_op), .ram_rdata(ram_rdata),
      .ram_wdata(ram_wdata), .ram_we(ram_we), .skip_req(skip_req)
   );
endmodule

// File: rtl/nram_bitop_chk.sv
module nram_bitop_chk
   import nram_pkg::*;
#(
   parameter int AW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] ram_addr,
   input logic [3:0]    ram_rdata,
   input logic [3:0]    ram_wdata,
   input logic          ram_we,
   input logic          skip_req,
   input logic          phase_b,
   input logic [7:0]    exec_op,
   input logic [7:0]    opd_q,
   input logic          prefix_q
);
   // R10
   we_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || skip_req) |-> phase_b);

   // R8
   tst_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_req |-> !ram_we);

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_b |-> $stable(ram_addr));

   // R4
   prefix_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_b && prefix_q) |-> ram_addr[AW-1]);

   // R3
   ld_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_b && exec_op == OP_LDPTR) |=> (ram_addr[3:0] == $past(opd_q[3:0])));

   // R6
   clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && (exec_op & BITOP_SEL) == OP_CLRB) |-> (ram_wdata[exec_op[1:0]] == 1'b0));

   // R7
   set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && (exec_op & BITOP_SEL) == OP_SETB) |-> (ram_wdata[exec_op[1:0]] == 1'b1));
endmodule

bind nram_bitop_unit nram_bitop_chk #(.AW(DATA_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
   .ram_wdata(ram_wdata), .ram_we(ram_we), .skip_req(skip_req),
   .phase_b(phase_b), .exec_op(exec_op), .opd_q(opd_q), .prefix_q(prefix_q)
);

// File: tb/nram_bitop_unit_tb_top.sv
module nram_bitop_unit_tb_top;
   localparam int AW = 7;
   localparam int DEPTH = 1 << AW;

   typedef struct {
      logic [AW-1:0] addr;
      logic          we;
      logic [3:0]    wdata;
      logic          skip;
      string         tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ins_valid = 1'b0;
   logic [7:0] ins_op = 8'h00;
   logic [7:0] ins_operand = 8'h00;
   logic ins_kill = 1'b0;
   logic [AW-1:0] ram_addr;
   logic [3:0] ram_rdata;
   logic [3:0] ram_wdata;
   logic ram_we;
   logic skip_req;

   int n_chk = 0;
   int n_fail = 0;
   exp_t sb[$];

   logic [3:0] ram [DEPTH];
   logic [3:0] mdl [DEPTH];
   logic [3:0] m_col = 4'h0;
   logic [AW-5:0] m_bank = '0;
   logic m_pre = 1'b0;
   logic tb_phb = 1'b0;

   always #4 clk = ~clk;

   nram_bitop_unit #(.DATA_AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
      .ins_operand(ins_operand), .ins_kill(ins_kill), .ram_addr(ram_addr),
      .ram_rdata(ram_rdata), .ram_wdata(ram_wdata), .ram_we(ram_we),
      .skip_req(skip_req)
   );

   // synchronous-read RAM model
   always @(posedge clk) begin
      if (ram_we) ram[ram_addr] <= ram_wdata;
      ram_rdata <= ram[ram_addr];
   end

   // bench view of the instruction phase (R11: strobe in second cycle ignored)
   always @(posedge clk) begin
      if (!rst_n) tb_phb <= 1'b0;
      else        tb_phb <= ins_valid && !tb_phb;
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // monitor: pops expected items in the second cycle of each instruction
   always @(negedge clk) begin
      if (rst_n && tb_phb) begin
         if (sb.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R11 unexpected instruction: actual 1 expected 0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "ram_addr", int'(ram_addr), int'(e.addr));
            check(e.tag, "ram_we", int'(ram_we), int'(e.we));
            check(e.tag, "skip_req", int'(skip_req), int'(e.skip));
            if (e.we) check(e.tag, "ram_wdata", int'(ram_wdata), int'(e.wdata));
         end
      end else if (rst_n && (ram_we || skip_req)) begin
         n_chk++; n_fail++;
         $display("FAIL R10 we/skip outside second cycle: actual %0d%0d expected 00",
                  ram_we, skip_req);
      end
   end

   task automatic issue(input logic [7:0] op, input logic [7:0] opd, input logic kill,
                        input string tag, input logic ghost = 1'b0);
      exp_t e;
      logic [7:0] x;
      logic [AW-1:0] a;
      logic [3:0] rd;
      logic [3:0] bm;
      @(negedge clk);
      x  = kill ? 8'h00 : op;
      a  = {m_bank, m_col};
      if (m_pre) a[AW-1] = 1'b1;
      rd = mdl[a];
      bm = 4'b0001 << x[1:0];
      e.addr = a; e.we = 1'b0; e.wdata = 4'h0; e.skip = 1'b0; e.tag = tag;
      if (x >= 8'h04 && x <= 8'h07) begin
         e.we = 1'b1; e.wdata = rd & ~bm;
      end else if (x >= 8'h0C && x <= 8'h0F) begin
         e.we = 1'b1; e.wdata = rd | bm;
      end else if (x >= 8'h54 && x <= 8'h57) begin
         e.skip = (rd & bm) != 4'h0;
      end
      if (e.we) mdl[a] = e.wdata;
      if (x == 8'h5F) begin
         m_col  = opd[3:0];
         m_bank = opd[AW-1:4];
      end
      m_pre = (x == 8'h02);
      sb.push_back(e);
      ins_valid = 1'b1; ins_op = op; ins_operand = opd; ins_kill = kill;
      @(negedge clk);
      if (ghost) begin
         ins_op = 8'h04; ins_kill = 1'b0;   // stray clear-bit in second cycle
         @(negedge clk);
         ins_valid = 1'b0;
      end else begin
         ins_valid = 1'b0;
      end
      ins_op = 8'h00; ins_kill = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         ram[i] = 4'((i * 7 + 3) & 15);
         mdl[i] = 4'((i * 7 + 3) & 15);
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "ram_addr", int'(ram_addr), 0);
      check("R1", "ram_we", int'(ram_we), 0);
      check("R1", "skip_req", int'(skip_req), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 default pointer, R10 unrelated opcode
      issue(8'h20, 8'h00, 1'b0, "R2");
      // R3 load pointer
      issue(8'h5F, 8'h25, 1'b0, "R3");
      issue(8'h54, 8'h00, 1'b0, "R3");
      // R5 R6 R7 R8 every bit position
      for (int b = 0; b < 4; b++) begin
         issue(8'h0C | 8'(b), 8'h00, 1'b0, "R7");
         issue(8'h54 | 8'(b), 8'h00, 1'b0, "R5");
         issue(8'h04 | 8'(b), 8'h00, 1'b0, "R6");
         issue(8'h54 | 8'(b), 8'h00, 1'b0, "R8");
      end
      // R4 prefix for exactly one instruction
      issue(8'h02, 8'h00, 1'b0, "R4");
      issue(8'h0D, 8'h00, 1'b0, "R4");
      issue(8'h55, 8'h00, 1'b0, "R4");
      issue(8'h02, 8'h00, 1'b0, "R4");
      issue(8'h56, 8'h00, 1'b0, "R4");
      issue(8'h06, 8'h00, 1'b0, "R4");
      // R9 skipped instructions
      issue(8'h02, 8'h00, 1'b1, "R9");
      issue(8'h0E, 8'h00, 1'b0, "R9");
      issue(8'h0F, 8'h00, 1'b1, "R9");
      issue(8'h57, 8'h00, 1'b0, "R9");
      issue(8'h5F, 8'h11, 1'b1, "R9");
      issue(8'h54, 8'h00, 1'b0, "R9");
      // R3 operand bits above the address width are dropped
      issue(8'h5F, 8'hF3, 1'b0, "R3");
      issue(8'h0C, 8'h00, 1'b0, "R3");
      issue(8'h54, 8'h00, 1'b0, "R3");
      // R11 stray strobe in the second cycle
      issue(8'h0D, 8'h00, 1'b0, "R11", 1'b1);
      issue(8'h54, 8'h00, 1'b0, "R11");
      issue(8'h55, 8'h00, 1'b0, "R11");
      // R10 non-bit opcodes
      issue(8'h08, 8'h00, 1'b0, "R10");
      issue(8'h53, 8'h00, 1'b0, "R10");
      issue(8'h58, 8'h00, 1'b0, "R10");

      repeat (4) @(negedge clk);
      check("R11", "scoreboard left", sb.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule